// File: doc/BRIEF.md
# Processor Reset State Controller

This block puts a processor core into its architected reset state and keeps a record of why the most recent reset happened. Reset requests can come from the core, chip and system reset lines, from a watchdog expiry that software has armed, and from a reset-request field that software writes. The controller holds the core in reset for as long as any request stays active. While reset is held it forces the machine-state register, the debug reset-request field and the watchdog reset-enable field to zero. It also re-establishes a single boot translation entry.

When the last request drops, the block loads the reset-type status. It also loads the watchdog status, but only when the watchdog took part in the reset. In the same cycle it issues a one-cycle start pulse at the fixed boot fetch address. Until software pulses the invalidate input, a small access checker enforces the boot page at the top of the address space. In that page, fetches and reads are allowed, writes are refused, and any other address is reported as a translation miss. A version register returns a fixed value at all times.

Top module: `reset_state_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it ends, the machine-state register output is 0. Software writes to it (select 0, data bits [31:0]) take effect on the next cycle, but only when no reset is held.
- R2: The debug reset-request field (select 1, data bits [1:0]) is cleared while reset is held. Writing a nonzero value to it requests a reset of that type.
- R3: Reset types are encoded as 1 = core, 2 = chip and 3 = system. The reset-type status is loaded at release with the highest type that was requested at any point during the hold, and it is visible on the cycle after release.
- R4: The watchdog reset-enable field (select 2, data bits [1:0]) is cleared while reset is held. A watchdog expiry requests a reset only when this field is nonzero, and the requested type is the field's value.
- R5: The watchdog status is loaded with the recorded type only when a watchdog expiry took part in the reset. After any other reset it keeps its previous value.
- R6: The fetch-start output pulses for exactly one cycle, on the cycle after release. The fetch address output is always 0xFFFFFFFC.
- R7: While the boot entry is valid and no reset is held, an access to 0xFFFFF000 or above raises the allow output one cycle later for a fetch (kind 0) or a read (kind 1). A write (kind 2) to that range raises the deny output instead.
- R8: While the boot entry is valid and no reset is held, an access below 0xFFFFF000 raises the miss output for exactly one cycle, one cycle later. Allow and deny stay low.
- R9: The boot entry stays valid until the invalidate input is pulsed outside a reset. After that, accesses produce no allow, deny or miss response until the next reset makes the entry valid again.
- R10: Writing to select 3 clears status bits. Data bits [1:0] clear the matching bits of the reset-type status, and bits [3:2] clear the matching bits of the watchdog status. Reset requests never clear these fields, and writes made while reset is held are ignored.
- R11: The version output equals the parameter PVR_VAL at all times.
- R12: Reset stays held while any request is active. Release happens on the first clock edge at which no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on initialisation, active low |
| req_core | input | 1 | Core reset request |
| req_chip | input | 1 | Chip reset request |
| req_sys | input | 1 | System reset request |
| wd_expire | input | 1 | Watchdog timer expiry |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 machine state, 1 debug reset request, 2 watchdog enable, 3 status clear |
| wr_data | input | 32 | Write data |
| boot_inval | input | 1 | Invalidate the boot translation entry |
| acc_valid | input | 1 | Access check request |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write |
| acc_addr | input | 32 | Effective address of the access |
| msr_o | output | 32 | Machine-state register |
| dbg_rst_o | output | 2 | Debug reset-request field |
| wd_en_o | output | 2 | Watchdog reset-enable field |
| rst_type_o | output | 2 | Reset-type status |
| wd_rst_type_o | output | 2 | Watchdog reset status |
| fetch_start_o | output | 1 | One-cycle start pulse after release |
| fetch_addr_o | output | 32 | Initial fetch address |
| acc_ok_o | output | 1 | Access allowed by the boot entry |
| acc_deny_o | output | 1 | Write to the boot page refused |
| acc_miss_o | output | 1 | Access outside the boot page |
| pvr_o | output | 32 | Processor version value |

## Verification
Every result here arrives one clock edge after the stimulus that causes it. A request first seen at edge N holds reset from edge N. If the last request drops before edge M, the status fields and the start pulse appear after edge M. A write or an access sampled at one edge shows on the outputs after that same edge. The bench drives inputs at the falling edge and advances a behavioural model at each rising edge. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. Directed checks with literal values confirm the priority, retention and W1C cases.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam logic [1:0] RT_NONE = 2'd0;
    localparam logic [1:0] RT_CORE = 2'd1;
    localparam logic [1:0] RT_CHIP = 2'd2;
    localparam logic [1:0] RT_SYS  = 2'd3;

    localparam logic [1:0] AK_FETCH = 2'd0;
    localparam logic [1:0] AK_READ  = 2'd1;
    localparam logic [1:0] AK_WRITE = 2'd2;

    localparam logic [1:0] SEL_MSR  = 2'd0;
    localparam logic [1:0] SEL_DBG  = 2'd1;
    localparam logic [1:0] SEL_WDEN = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    // Higher code means higher priority: system > chip > core.
    function automatic logic [1:0] kind_max(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/rsc_cause_latch.sv
module rsc_cause_latch
    import rsc_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       req_core,
    input  logic       req_chip,
    input  logic       req_sys,
    input  logic [1:0] sw_kind,
    input  logic       wd_fire,
    input  logic [1:0] wd_kind,
    output logic       held_o,
    output logic       end_o,
    output logic [1:0] kind_o,
    output logic       wd_o
);
    typedef struct packed {
        logic       held;
        logic [1:0] kind;
        logic       wd;
    } latch_t;

    latch_t st_q, st_d;
    logic       any_req;
    logic [1:0] hw_kind;
    logic [1:0] cur_kind;

    always_comb begin
        hw_kind  = req_sys ? RT_SYS : (req_chip ? RT_CHIP : (req_core ? RT_CORE : RT_NONE));
        cur_kind = kind_max(hw_kind, kind_max(sw_kind, wd_fire ? wd_kind : RT_NONE));
        any_req  = req_core | req_chip | req_sys | (sw_kind != RT_NONE) | wd_fire;
        st_d     = st_q;
        st_d.held = any_req;
        if (any_req) begin
            st_d.kind = st_q.held ? kind_max(st_q.kind, cur_kind) : cur_kind;
            st_d.wd   = (st_q.held & st_q.wd) | wd_fire;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_o = st_q.held;
    assign end_o  = st_q.held & ~any_req;
    assign kind_o = st_q.kind;
    assign wd_o   = st_q.wd;

    AST_SYS_WINS: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.held && req_sys) |=> (st_q.kind == RT_SYS)); // R3
    AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!por_n)
        (req_core || req_chip || req_sys) |=> st_q.held); // R12
endmodule

// File: rtl/rsc_boot_check.sv
module rsc_boot_check
    import rsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              entry_live,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              ok_o,
    output logic              deny_o,
    output logic              miss_o
);
    localparam logic [ADDR_W-1:0] PAGE_BASE = {ADDR_W{1'b1}} << PAGE_SHIFT;

    typedef struct packed {
        logic ok;
        logic deny;
        logic miss;
    } resp_t;

    resp_t rs_q, rs_d;
    logic  in_page;
    logic  probe;

    always_comb begin
        in_page    = (acc_addr >= PAGE_BASE);
        probe      = acc_valid & entry_live;
        rs_d.ok    = probe & in_page & (acc_kind != AK_WRITE);
        rs_d.deny  = probe & in_page & (acc_kind == AK_WRITE);
        rs_d.miss  = probe & ~in_page;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign ok_o   = rs_q.ok;
    assign deny_o = rs_q.deny;
    assign miss_o = rs_q.miss;

    AST_MISS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!por_n)
        rs_q.miss |-> (!rs_q.ok && !rs_q.deny)); // R8
    AST_DENY_ONLY_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        rs_q.deny |-> ($past(acc_kind) == AK_WRITE)); // R7
endmodule

// File: rtl/reset_state_ctrl.sv
module reset_state_ctrl
    import rsc_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          MSR_W      = 32,
    parameter int          PAGE_SHIFT = 12,
    parameter logic [31:0] PVR_VAL    = 32'h5A31_0207
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              req_core,
    input  logic              req_chip,
    input  logic              req_sys,
    input  logic              wd_expire,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [MSR_W-1:0]  wr_data,
    input  logic              boot_inval,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [MSR_W-1:0]  msr_o,
    output logic [1:0]        dbg_rst_o,
    output logic [1:0]        wd_en_o,
    output logic [1:0]        rst_type_o,
    output logic [1:0]        wd_rst_type_o,
    output logic              fetch_start_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              acc_ok_o,
    output logic              acc_deny_o,
    output logic              acc_miss_o,
    output logic [31:0]       pvr_o
);
    localparam logic [ADDR_W-1:0] BOOT_PC = {ADDR_W{1'b1}} << 2;

    typedef struct packed {
        logic [MSR_W-1:0] msr;
        logic [1:0]       dbg;
        logic [1:0]       wden;
        logic [1:0]       rtype;
        logic [1:0]       wdtype;
        logic             boot_ok;
        logic             start;
    } ctl_t;

    ctl_t c_q, c_d;
    logic       held, rel, wd_took_part;
    logic [1:0] rec_kind;
    logic       wd_fire;

    assign wd_fire = wd_expire & (c_q.wden != RT_NONE);

    rsc_cause_latch u_cause (
        .clk     (clk),
        .por_n   (por_n),
        .req_core(req_core),
        .req_chip(req_chip),
        .req_sys (req_sys),
        .sw_kind (c_q.dbg),
        .wd_fire (wd_fire),
        .wd_kind (c_q.wden),
        .held_o  (held),
        .end_o   (rel),
        .kind_o  (rec_kind),
        .wd_o    (wd_took_part)
    );

    always_comb begin
        c_d       = c_q;
        c_d.start = rel;
        if (held) begin
            c_d.msr     = '0;
            c_d.dbg     = RT_NONE;
            c_d.wden    = RT_NONE;
            c_d.boot_ok = 1'b1;
        end else begin
            if (wr_en) begin
                case (wr_sel)
                    SEL_MSR:  c_d.msr  = wr_data;
                    SEL_DBG:  c_d.dbg  = wr_data[1:0];
                    SEL_WDEN: c_d.wden = wr_data[1:0];
                    default: begin
                        c_d.rtype  = c_q.rtype  & ~wr_data[1:0];
                        c_d.wdtype = c_q.wdtype & ~wr_data[3:2];
                    end
                endcase
            end
            if (boot_inval) c_d.boot_ok = 1'b0;
        end
        if (rel) begin
            c_d.rtype = rec_kind;
            if (wd_took_part) c_d.wdtype = rec_kind;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            c_q         <= '0;
            c_q.boot_ok <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    rsc_boot_check #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_boot (
        .clk       (clk),
        .por_n     (por_n),
        .entry_live(c_q.boot_ok & ~held),
        .acc_valid (acc_valid),
        .acc_kind  (acc_kind),
        .acc_addr  (acc_addr),
        .ok_o      (acc_ok_o),
        .deny_o    (acc_deny_o),
        .miss_o    (acc_miss_o)
    );

    assign msr_o         = c_q.msr;
    assign dbg_rst_o     = c_q.dbg;
    assign wd_en_o       = c_q.wden;
    assign rst_type_o    = c_q.rtype;
    assign wd_rst_type_o = c_q.wdtype;
    assign fetch_start_o = c_q.start;
    assign fetch_addr_o  = BOOT_PC;
    assign pvr_o         = PVR_VAL;

    AST_CLEAN_AT_START: assert property (@(posedge clk) disable iff (!por_n)
        fetch_start_o |-> (msr_o == '0 && dbg_rst_o == RT_NONE && wd_en_o == RT_NONE)); // R1
    AST_WD_STATUS_KEPT: assert property (@(posedge clk) disable iff (!por_n)
        (rel && !wd_took_part) |=> $stable(wd_rst_type_o)); // R5
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        fetch_start_o |=> !fetch_start_o); // R6
    AST_STATUS_SET_AT_START: assert property (@(posedge clk) disable iff (!por_n)
        fetch_start_o |-> (rst_type_o != RT_NONE)); // R3
endmodule

// File: tb/reset_state_ctrl_bench.sv
module reset_state_ctrl_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        req_core = 0, req_chip = 0, req_sys = 0, wd_expire = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic        boot_inval = 0, acc_valid = 0;
    logic [1:0]  acc_kind = 0;
    logic [31:0] acc_addr = 0;
    logic [31:0] msr_o, fetch_addr_o, pvr_o;
    logic [1:0]  dbg_rst_o, wd_en_o, rst_type_o, wd_rst_type_o;
    logic        fetch_start_o, acc_ok_o, acc_deny_o, acc_miss_o;

    int checks = 0, errors = 0, cycles = 0, starts = 0;
    bit done = 0;

    always #10 clk = ~clk;

    reset_state_ctrl u_reset_state_ctrl (
        .clk(clk), .por_n(por_n), .req_core(req_core), .req_chip(req_chip), .req_sys(req_sys),
        .wd_expire(wd_expire), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .boot_inval(boot_inval), .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
        .msr_o(msr_o), .dbg_rst_o(dbg_rst_o), .wd_en_o(wd_en_o), .rst_type_o(rst_type_o),
        .wd_rst_type_o(wd_rst_type_o), .fetch_start_o(fetch_start_o), .fetch_addr_o(fetch_addr_o),
        .acc_ok_o(acc_ok_o), .acc_deny_o(acc_deny_o), .acc_miss_o(acc_miss_o), .pvr_o(pvr_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model of the requirements
    logic        m_held, m_wd, m_start, m_ok, m_deny, m_miss, m_boot;
    logic [1:0]  m_kind, m_dbg, m_wden, m_rt, m_wrs;
    logic [31:0] m_msr;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_held = 0; m_wd = 0; m_start = 0; m_ok = 0; m_deny = 0; m_miss = 0; m_boot = 1;
            m_kind = 0; m_dbg = 0; m_wden = 0; m_rt = 0; m_wrs = 0; m_msr = 0;
        end else begin
            bit fire, anyr, fin, live, inpg;
            int cur;
            fire = wd_expire && (m_wden != 0);
            cur = 0;
            if (req_core) cur = 1;
            if (req_chip) cur = 2;
            if (req_sys)  cur = 3;
            if (int'(m_dbg) > cur) cur = int'(m_dbg);
            if (fire && int'(m_wden) > cur) cur = int'(m_wden);
            anyr = req_core || req_chip || req_sys || (m_dbg != 0) || fire;
            fin  = m_held && !anyr;
            live = m_boot && !m_held;
            inpg = (acc_addr >= 32'hFFFF_F000);
            m_ok   = acc_valid && live && inpg && (acc_kind != 2);
            m_deny = acc_valid && live && inpg && (acc_kind == 2);
            m_miss = acc_valid && live && !inpg;
            m_start = fin;
            if (fin) begin
                m_rt = m_kind;
                if (m_wd) m_wrs = m_kind;
            end else if (!m_held && wr_en && wr_sel == 3) begin
                m_rt  = m_rt & ~wr_data[1:0];
                m_wrs = m_wrs & ~wr_data[3:2];
            end
            if (m_held) begin
                m_msr = 0; m_dbg = 0; m_wden = 0; m_boot = 1;
            end else begin
                if (wr_en && wr_sel == 0) m_msr = wr_data;
                if (wr_en && wr_sel == 1) m_dbg = wr_data[1:0];
                if (wr_en && wr_sel == 2) m_wden = wr_data[1:0];
                if (boot_inval) m_boot = 0;
            end
            if (anyr) begin
                if (m_held) begin
                    if (cur > int'(m_kind)) m_kind = 2'(cur);
                    m_wd = m_wd || fire;
                end else begin
                    m_kind = 2'(cur);
                    m_wd = fire;
                end
            end
            m_held = anyr;
        end
    end

    always @(negedge clk) begin
        if (por_n && !done) begin
            if (fetch_start_o) starts++;
            chk("R1", "msr", msr_o, m_msr);
            chk("R2", "dbg_rst", {30'd0, dbg_rst_o}, {30'd0, m_dbg});
            chk("R3", "rst_type", {30'd0, rst_type_o}, {30'd0, m_rt});
            chk("R4", "wd_en", {30'd0, wd_en_o}, {30'd0, m_wden});
            chk("R5", "wd_rst_type", {30'd0, wd_rst_type_o}, {30'd0, m_wrs});
            chk("R6", "fetch_start", {31'd0, fetch_start_o}, {31'd0, m_start});
            chk("R7", "ok/deny", {30'd0, acc_ok_o, acc_deny_o}, {30'd0, m_ok, m_deny});
            chk("R8", "miss", {31'd0, acc_miss_o}, {31'd0, m_miss});
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = 0;
    endtask

    task automatic access(input logic [1:0] k, input logic [31:0] a, input bit eo, input bit ed,
                          input bit em, input string req);
        acc_valid = 1; acc_kind = k; acc_addr = a;
        @(negedge clk);
        acc_valid = 0;
        chk(req, "access ok", {31'd0, acc_ok_o}, {31'd0, eo});
        chk(req, "access deny", {31'd0, acc_deny_o}, {31'd0, ed});
        chk(req, "access miss", {31'd0, acc_miss_o}, {31'd0, em});
    endtask

    initial begin
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(2);
        por_n = 1;
        idle(1);
        // Reset state after power-on
        chk("R3", "por rst_type", {30'd0, rst_type_o}, 32'd0);
        chk("R1", "por msr", msr_o, 32'd0);
        chk("R6", "fetch addr", fetch_addr_o, 32'hFFFF_FFFC);
        chk("R11", "version", pvr_o, 32'h5A31_0207);

        // R1: write msr, then a core reset clears it
        wr(0, 32'h0000_A5A5);
        chk("R1", "msr written", msr_o, 32'h0000_A5A5);
        req_core = 1; idle(2); req_core = 0; idle(3);
        chk("R3", "core type", {30'd0, rst_type_o}, 32'd1);
        chk("R1", "msr cleared", msr_o, 32'd0);
        chk("R6", "one start per reset", starts, 1);

        // R12, R3: overlapping requests, system briefly inside the hold
        req_core = 1; idle(1); req_chip = 1; idle(1); req_sys = 1; idle(1); req_sys = 0;
        idle(2); req_core = 0; idle(2);
        chk("R12", "still held", {31'd0, fetch_start_o}, 32'd0);
        req_chip = 0; idle(3);
        chk("R3", "system wins", {30'd0, rst_type_o}, 32'd3);

        // R10: partial then full W1C
        wr(3, 32'h1); idle(1);
        chk("R10", "clear bit0", {30'd0, rst_type_o}, 32'd2);
        wr(3, 32'h3); idle(1);
        chk("R10", "clear all", {30'd0, rst_type_o}, 32'd0);

        // R4: expiry with enable clear has no effect
        wd_expire = 1; idle(2); wd_expire = 0; idle(2);
        chk("R4", "disarmed watchdog", {30'd0, rst_type_o}, 32'd0);

        // R4, R5: armed watchdog chip reset
        wr(2, 32'h2);
        wd_expire = 1; idle(1); wd_expire = 0; idle(4);
        chk("R5", "wd status set", {30'd0, wd_rst_type_o}, 32'd2);
        chk("R4", "wd enable cleared", {30'd0, wd_en_o}, 32'd0);

        // R5: plain core reset keeps watchdog status
        req_core = 1; idle(1); req_core = 0; idle(3);
        chk("R5", "wd status kept", {30'd0, wd_rst_type_o}, 32'd2);
        chk("R3", "core after wd", {30'd0, rst_type_o}, 32'd1);

        // R2: software reset request
        wr(1, 32'h3); idle(5);
        chk("R2", "sw reset type", {30'd0, rst_type_o}, 32'd3);
        chk("R2", "dbg cleared", {30'd0, dbg_rst_o}, 32'd0);

        // R1, R10: writes while held are ignored
        req_core = 1; idle(1);
        wr(0, 32'hFFFF_FFFF); wr(3, 32'hF);
        req_core = 0; idle(3);
        chk("R1", "held write ignored", msr_o, 32'd0);
        chk("R10", "held clear ignored", {30'd0, wd_rst_type_o}, 32'd2);

        // R7, R8: boot page checks
        access(0, 32'hFFFF_FFFC, 1, 0, 0, "R7");
        access(1, 32'hFFFF_F000, 1, 0, 0, "R7");
        access(2, 32'hFFFF_F800, 0, 1, 0, "R7");
        access(1, 32'h0000_1000, 0, 0, 1, "R8");
        access(0, 32'hFFFF_EFFC, 0, 0, 1, "R8");
        idle(1);
        chk("R8", "miss lasts one cycle", {31'd0, acc_miss_o}, 32'd0);

        // R9: invalidate, then reset restores
        boot_inval = 1; idle(1); boot_inval = 0;
        access(1, 32'hFFFF_F100, 0, 0, 0, "R9");
        access(1, 32'h0000_0040, 0, 0, 0, "R9");
        req_chip = 1; idle(1); req_chip = 0; idle(2);
        access(0, 32'hFFFF_F200, 1, 0, 0, "R9");

        // R10: clear watchdog status
        wr(3, 32'hC); idle(1);
        chk("R10", "wd status cleared", {30'd0, wd_rst_type_o}, 32'd0);
        chk("R11", "version steady", pvr_o, 32'h5A31_0207);

        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule